// File: doc/BRIEF.md
# Graphics Ingress Background-Colour Packet Decoder

This block sits between a DMA channel and a graphics register block. It takes a stream of 128-bit quadwords from one fixed source path (the path fed by DMA channel 2) and reads them as a two-beat packet. The first beat is a tag and the second holds a colour. When the tag names exactly one register and that register is the background colour, the block issues one register write with a fixed offset and a 24-bit RGB value. It then pulses a done signal back to the DMA side. It is the only route into the register block, so every colour update has to pass through the DMA stream.

The block has no arbitration, because there is only one input path. The only destination it decodes is the background colour. A tag that asks for anything else is dropped. The drop is flagged in the tag trace record and in the done status, and no write goes out. Two trace records are produced. The tag record carries the source path, a tag summary, the target register field and the register count. The write record carries the offset, the value, the source id and a field that is always zero.

Top module: `gfx_pkt_decoder`

## Requirements
- R1: After reset, `in_ready` is 1 and `wr_en`, `pkt_done`, `pkt_err`, `tag_trc_vld` and `wr_trc_vld` are 0.
- R2: A beat taken while waiting for a tag is decoded as a tag. Bits [3:0] hold the register count and bits [11:4] hold the register select. In the cycle after the beat is taken, `tag_trc_vld` pulses for one cycle with these fields: `tag_trc_path` = `PATH_ID` (2), `tag_trc_sum` = tag[15:0], `tag_trc_target` = tag[11:4] and `tag_trc_count` = tag[3:0].
- R3: A tag whose count is not 1, or whose select is not `BG_SEL` (0x0E), is dropped. In the same cycle as its tag trace, `tag_trc_err` = 1, `pkt_done` = 1 and `pkt_err` = 1, and no register write is issued. The next beat is decoded as a new tag.
- R4: A valid tag is followed by one colour beat. In the cycle after that beat is taken, `wr_en` pulses exactly once with `wr_ofs` = `BG_OFS` (0xE0) and `wr_data` = beat[23:0]. In that field, R is in bits [7:0], G in bits [15:8] and B in bits [23:16].
- R5: `wr_trc_vld` pulses in the same cycle as `wr_en`, with `wr_trc_ofs` = 0xE0, `wr_trc_val` equal to the written colour, `wr_trc_src` = 2 and `wr_trc_rsvd` = 0.
- R6: `in_ready` is 0 during the write cycle and during the done cycle. A beat offered in those cycles is not consumed.
- R7: `pkt_done` pulses for one cycle, in the cycle after `wr_en`, with `pkt_err` = 0. `in_ready` is 1 again in the cycle after that.
- R8: While `in_valid` is 0, the decoder holds its place in the packet. Idle cycles between the tag and the colour beat do not change the result.
- R9: Colour-beat bits [127:24] have no effect on the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | DMA beat valid |
| in_data | input | 128 | DMA quadword |
| in_ready | output | 1 | Decoder can take a beat |
| pkt_done | output | 1 | Packet accepted (one-cycle pulse) |
| pkt_err | output | 1 | Packet was dropped (valid with pkt_done) |
| wr_en | output | 1 | Register write strobe |
| wr_ofs | output | 8 | Register write offset |
| wr_data | output | 24 | Register write RGB value |
| tag_trc_vld | output | 1 | Tag trace record valid |
| tag_trc_path | output | 4 | Source path id |
| tag_trc_sum | output | 16 | Tag summary (low tag bits) |
| tag_trc_target | output | 8 | Register select field |
| tag_trc_count | output | 4 | Register count field |
| tag_trc_err | output | 1 | Tag was rejected |
| wr_trc_vld | output | 1 | Write trace record valid |
| wr_trc_ofs | output | 8 | Traced offset |
| wr_trc_val | output | 24 | Traced value |
| wr_trc_src | output | 4 | Traced source id |
| wr_trc_rsvd | output | 8 | Reserved, zero |

## Verification
For a rejected tag, three events share one cycle: the tag trace with its error flag, the done pulse and the error status. Every bad tag in the vector table checks all three together, and checks that no write strobe comes out with them. The other collision is a DMA beat offered while the write strobe is being issued. The bench holds `in_valid` high with junk data through the write and done cycles. It then judges the outcome two ways: the write count must stay at one, and the next packet must decode as a fresh tag.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
  typedef enum logic [1:0] {
    ST_TAG   = 2'd0,
    ST_DATA  = 2'd1,
    ST_WRITE = 2'd2,
    ST_ACK   = 2'd3
  } gpd_state_e;
endpackage

// File: rtl/gpd_tag_decode.sv
module gpd_tag_decode #(
  parameter int QW_W  = 128,
  parameter int CNT_W = 4,
  parameter int SEL_W = 8,
  parameter logic [SEL_W-1:0] BG_SEL = 8'h0E
) (
  input  logic [QW_W-1:0]  tag,
  output logic [CNT_W-1:0] cnt,
  output logic [SEL_W-1:0] sel,
  output logic             ok
);
  localparam int SEL_LSB = CNT_W;

  always_comb begin
    cnt = tag[CNT_W-1:0];
    sel = tag[SEL_LSB +: SEL_W];
    ok  = (cnt == CNT_W'(1)) && (sel == BG_SEL);
  end
endmodule

// File: rtl/gpd_ctrl.sv
module gpd_ctrl
  import gpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic tag_ok,
  output logic in_ready,
  output logic take_tag,
  output logic take_data,
  output logic wr_en,
  output logic pkt_done,
  output logic pkt_err
);
  gpd_state_e state_q, state_d;
  logic       err_q;

  always_comb begin
    in_ready  = (state_q == ST_TAG) || (state_q == ST_DATA);
    take_tag  = in_valid && (state_q == ST_TAG);
    take_data = in_valid && (state_q == ST_DATA);
    wr_en     = (state_q == ST_WRITE);
    pkt_done  = (state_q == ST_ACK);
    pkt_err   = (state_q == ST_ACK) && err_q;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TAG:   if (take_tag) state_d = tag_ok ? ST_DATA : ST_ACK;
      ST_DATA:  if (take_data) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_ACK;
      ST_ACK:   state_d = ST_TAG;
      default:  state_d = ST_TAG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TAG;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_tag) err_q <= !tag_ok;
    end
  end
endmodule

// File: rtl/gpd_trace.sv
module gpd_trace #(
  parameter int QW_W   = 128,
  parameter int CNT_W  = 4,
  parameter int SEL_W  = 8,
  parameter int SUM_W  = 16,
  parameter int OFS_W  = 8,
  parameter int RGB_W  = 24,
  parameter int PATH_W = 4,
  parameter logic [PATH_W-1:0] PATH_ID = 4'd2,
  parameter logic [OFS_W-1:0]  BG_OFS  = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_tag,
  input  logic              take_data,
  input  logic [QW_W-1:0]   beat,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SEL_W-1:0]  sel,
  input  logic              tag_ok,
  output logic              tag_trc_vld,
  output logic [PATH_W-1:0] tag_trc_path,
  output logic [SUM_W-1:0]  tag_trc_sum,
  output logic [SEL_W-1:0]  tag_trc_target,
  output logic [CNT_W-1:0]  tag_trc_count,
  output logic              tag_trc_err,
  output logic              wr_trc_vld,
  output logic [OFS_W-1:0]  wr_trc_ofs,
  output logic [RGB_W-1:0]  wr_trc_val,
  output logic [PATH_W-1:0] wr_trc_src,
  output logic [7:0]        wr_trc_rsvd
);
  logic tvld_q, wvld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvld_q <= 1'b0;
      wvld_q <= 1'b0;
    end else begin
      tvld_q <= take_tag;
      wvld_q <= take_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_trc_sum    <= '0;
      tag_trc_target <= '0;
      tag_trc_count  <= '0;
      tag_trc_err    <= 1'b0;
    end else if (take_tag) begin
      tag_trc_sum    <= beat[SUM_W-1:0];
      tag_trc_target <= sel;
      tag_trc_count  <= cnt;
      tag_trc_err    <= !tag_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_trc_val <= '0;
    else if (take_data) wr_trc_val <= beat[RGB_W-1:0];
  end

  always_comb begin
    tag_trc_vld  = tvld_q;
    tag_trc_path = tvld_q ? PATH_ID : '0;
    wr_trc_vld   = wvld_q;
    wr_trc_ofs   = wvld_q ? BG_OFS : '0;
    wr_trc_src   = wvld_q ? PATH_ID : '0;
    wr_trc_rsvd  = '0;
  end
endmodule

// File: rtl/gfx_pkt_decoder.sv
module gfx_pkt_decoder #(
  parameter int QW_W   = 128,
  parameter int CNT_W  = 4,
  parameter int SEL_W  = 8,
  parameter int SUM_W  = 16,
  parameter int OFS_W  = 8,
  parameter int RGB_W  = 24,
  parameter int PATH_W = 4,
  parameter logic [PATH_W-1:0] PATH_ID = 4'd2,
  parameter logic [SEL_W-1:0]  BG_SEL  = 8'h0E,
  parameter logic [OFS_W-1:0]  BG_OFS  = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [QW_W-1:0]   in_data,
  output logic              in_ready,
  output logic              pkt_done,
  output logic              pkt_err,
  output logic              wr_en,
  output logic [OFS_W-1:0]  wr_ofs,
  output logic [RGB_W-1:0]  wr_data,
  output logic              tag_trc_vld,
  output logic [PATH_W-1:0] tag_trc_path,
  output logic [SUM_W-1:0]  tag_trc_sum,
  output logic [SEL_W-1:0]  tag_trc_target,
  output logic [CNT_W-1:0]  tag_trc_count,
  output logic              tag_trc_err,
  output logic              wr_trc_vld,
  output logic [OFS_W-1:0]  wr_trc_ofs,
  output logic [RGB_W-1:0]  wr_trc_val,
  output logic [PATH_W-1:0] wr_trc_src,
  output logic [7:0]        wr_trc_rsvd
);
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel;
  logic             tag_ok, take_tag, take_data;
  logic [RGB_W-1:0] colour_q;

  gpd_tag_decode #(.QW_W(QW_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .BG_SEL(BG_SEL)) u_dec (
    .tag(in_data), .cnt(cnt), .sel(sel), .ok(tag_ok)
  );

  gpd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tag_ok(tag_ok),
    .in_ready(in_ready), .take_tag(take_tag), .take_data(take_data),
    .wr_en(wr_en), .pkt_done(pkt_done), .pkt_err(pkt_err)
  );

  gpd_trace #(
    .QW_W(QW_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .SUM_W(SUM_W), .OFS_W(OFS_W),
    .RGB_W(RGB_W), .PATH_W(PATH_W), .PATH_ID(PATH_ID), .BG_OFS(BG_OFS)
  ) u_trc (
    .clk(clk), .rst_n(rst_n), .take_tag(take_tag), .take_data(take_data),
    .beat(in_data), .cnt(cnt), .sel(sel), .tag_ok(tag_ok),
    .tag_trc_vld(tag_trc_vld), .tag_trc_path(tag_trc_path), .tag_trc_sum(tag_trc_sum),
    .tag_trc_target(tag_trc_target), .tag_trc_count(tag_trc_count), .tag_trc_err(tag_trc_err),
    .wr_trc_vld(wr_trc_vld), .wr_trc_ofs(wr_trc_ofs), .wr_trc_val(wr_trc_val),
    .wr_trc_src(wr_trc_src), .wr_trc_rsvd(wr_trc_rsvd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) colour_q <= '0;
    else if (take_data) colour_q <= in_data[RGB_W-1:0];
  end

  always_comb begin
    wr_data = wr_en ? colour_q : '0;
    wr_ofs  = wr_en ? BG_OFS : '0;
  end
endmodule

// File: rtl/gpd_checker.sv
module gpd_checker #(
  parameter int OFS_W  = 8,
  parameter int RGB_W  = 24,
  parameter int PATH_W = 4,
  parameter logic [PATH_W-1:0] PATH_ID = 4'd2,
  parameter logic [OFS_W-1:0]  BG_OFS  = 8'hE0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              pkt_done,
  input logic              pkt_err,
  input logic              wr_en,
  input logic [OFS_W-1:0]  wr_ofs,
  input logic [RGB_W-1:0]  wr_data,
  input logic              tag_trc_vld,
  input logic [PATH_W-1:0] tag_trc_path,
  input logic              tag_trc_err,
  input logic              wr_trc_vld,
  input logic [RGB_W-1:0]  wr_trc_val,
  input logic [PATH_W-1:0] wr_trc_src
);
  AST_TAG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    tag_trc_vld |-> tag_trc_path == PATH_ID); // R2
  AST_BAD_TAG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_trc_vld && tag_trc_err) |-> (pkt_done && pkt_err && !wr_en)); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R4
  AST_WR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_ofs == BG_OFS); // R4
  AST_WR_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_trc_vld && wr_trc_val == wr_data && wr_trc_src == PATH_ID)); // R5
  AST_NO_RDY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || pkt_done) |-> !in_ready); // R6
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pkt_done && !pkt_err)); // R7
  AST_RDY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> in_ready); // R7
endmodule

bind gfx_pkt_decoder gpd_checker #(
  .OFS_W(OFS_W), .RGB_W(RGB_W), .PATH_W(PATH_W), .PATH_ID(PATH_ID), .BG_OFS(BG_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .pkt_done(pkt_done), .pkt_err(pkt_err),
  .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data), .tag_trc_vld(tag_trc_vld),
  .tag_trc_path(tag_trc_path), .tag_trc_err(tag_trc_err), .wr_trc_vld(wr_trc_vld),
  .wr_trc_val(wr_trc_val), .wr_trc_src(wr_trc_src)
);

// File: tb/gfx_pkt_decoder_tb.sv
module gfx_pkt_decoder_tb;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_data;
  logic         in_ready, pkt_done, pkt_err, wr_en;
  logic [7:0]   wr_ofs;
  logic [23:0]  wr_data;
  logic         tag_trc_vld, tag_trc_err, wr_trc_vld;
  logic [3:0]   tag_trc_path, tag_trc_count, wr_trc_src;
  logic [15:0]  tag_trc_sum;
  logic [7:0]   tag_trc_target, wr_trc_ofs, wr_trc_rsvd;
  logic [23:0]  wr_trc_val;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;

  gfx_pkt_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pkt_done(pkt_done), .pkt_err(pkt_err), .wr_en(wr_en),
    .wr_ofs(wr_ofs), .wr_data(wr_data), .tag_trc_vld(tag_trc_vld),
    .tag_trc_path(tag_trc_path), .tag_trc_sum(tag_trc_sum), .tag_trc_target(tag_trc_target),
    .tag_trc_count(tag_trc_count), .tag_trc_err(tag_trc_err), .wr_trc_vld(wr_trc_vld),
    .wr_trc_ofs(wr_trc_ofs), .wr_trc_val(wr_trc_val), .wr_trc_src(wr_trc_src),
    .wr_trc_rsvd(wr_trc_rsvd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n && wr_en) wr_cnt <= wr_cnt + 1;

  localparam int NV = 7;
  localparam logic [127:0] V_TAG [NV] = '{
    128'h0000_00E1,
    128'h0000_50E1,
    128'h0000_00E2,
    128'h0000_00F1,
    128'h0000_00E0,
    128'h1234_00E1,
    128'h0000_A0E1
  };
  localparam logic [127:0] V_DAT [NV] = '{
    128'h0011_2233,
    128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFA5_C3F0,
    128'h0,
    128'h0,
    128'h0,
    128'h0,
    128'hDEAD_BEEF_0000_0000_0000_0000_00FF_FFFF
  };
  localparam logic V_ERR [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [23:0] V_RGB [NV] = '{24'h112233, 24'hA5C3F0, 24'h0, 24'h0, 24'h0,
                                         24'h000000, 24'hFFFFFF};

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_pkt(input logic [127:0] tag, input logic [127:0] dat,
                         input logic exp_err, input logic [23:0] exp_rgb, input int idle);
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    check(in_ready, "R8 ready for tag", 128'(in_ready), 128'd1);
    in_valid = 1'b1; in_data = tag;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag_trc_vld && tag_trc_path == 4'd2 && tag_trc_sum == tag[15:0] &&
          tag_trc_target == tag[11:4] && tag_trc_count == tag[3:0],
          "R2 tag trace", {tag_trc_path, tag_trc_sum, tag_trc_target, tag_trc_count},
          {4'd2, tag[15:0], tag[11:4], tag[3:0]});
    check(tag_trc_err == exp_err, "R3 tag err flag", 128'(tag_trc_err), 128'(exp_err));
    if (exp_err) begin
      check(pkt_done && pkt_err && !wr_en, "R3 drop done+err",
            {pkt_done, pkt_err, wr_en}, 3'b110);
      @(negedge clk);
      check(in_ready && !pkt_done, "R3 back to tag", {in_ready, pkt_done}, 2'b10);
      check(wr_cnt == w0, "R3 no write", 128'(wr_cnt - w0), 128'd0);
    end else begin
      for (int i = 0; i < idle; i++) begin
        @(negedge clk);
        check(in_ready && !wr_en && !pkt_done, "R8 idle hold",
              {in_ready, wr_en, pkt_done}, 3'b100);
      end
      in_valid = 1'b1; in_data = dat;
      @(negedge clk);
      in_data = 128'h0000_00E1;  // junk beat offered during write (R6)
      check(wr_en && wr_ofs == 8'hE0 && wr_data == exp_rgb, "R4 write",
            {wr_en, wr_ofs, wr_data}, {1'b1, 8'hE0, exp_rgb});
      check(!in_ready, "R6 not ready in write", 128'(in_ready), 128'd0);
      check(wr_trc_vld && wr_trc_ofs == 8'hE0 && wr_trc_val == exp_rgb &&
            wr_trc_src == 4'd2 && wr_trc_rsvd == 8'h0, "R5 write trace",
            {wr_trc_vld, wr_trc_ofs, wr_trc_val, wr_trc_src, wr_trc_rsvd},
            {1'b1, 8'hE0, exp_rgb, 4'd2, 8'h0});
      @(negedge clk);
      in_valid = 1'b0;
      check(pkt_done && !pkt_err && !wr_en && !in_ready, "R7 done",
            {pkt_done, pkt_err, wr_en, in_ready}, 4'b1000);
      @(negedge clk);
      check(in_ready && !pkt_done && !tag_trc_vld, "R6 junk not consumed",
            {in_ready, pkt_done, tag_trc_vld}, 3'b100);
      check(wr_cnt == w0 + 1, "R4 one write", 128'(wr_cnt - w0), 128'd1);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !wr_en && !pkt_done && !pkt_err && !tag_trc_vld && !wr_trc_vld,
          "R1 reset state", {in_ready, wr_en, pkt_done, pkt_err, tag_trc_vld, wr_trc_vld},
          6'b100000);

    for (int v = 0; v < NV; v++) run_pkt(V_TAG[v], V_DAT[v], V_ERR[v], V_RGB[v], 0);

    // R8: idle cycles between tag and colour beat
    run_pkt(128'h0000_00E1, 128'h0077_8899, 1'b0, 24'h778899, 3);
    // R9: only bits [23:0] matter
    run_pkt(128'h0000_00E1, {104'hABCD_EF01_2345_6789_0FED_CBA9_87, 24'h010203}, 1'b0,
            24'h010203, 1);

    // R1/R3: reset mid-packet returns to tag decode
    @(negedge clk);
    in_valid = 1'b1; in_data = 128'h0000_00E1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !pkt_done && !wr_en, "R1 reset mid packet",
          {in_ready, pkt_done, wr_en}, 3'b100);
    run_pkt(128'h0000_0000, 128'h0, 1'b1, 24'h0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule